// File: doc/BRIEF.md
# Scan-Multiplexed RGB LED Matrix Panel Model

This block is a synthesizable behavioural stand-in for one scan-multiplexed RGB LED matrix panel. It lets a panel driver be checked against the panel's actual response. The driver feeds six serial colour bits on every rising edge of the shift clock. There is one bit for each of red, green and blue in the upper half of the panel, and one for each in the lower half. Each bit enters its own shift chain, and each chain is as long as the panel is wide.

A level-sensitive latch sits behind each chain. While the latch strobe is high, the latch passes the chain contents straight through. While the strobe is low, the latch holds them. The latched bits are the column sink states of the panel. A row decoder without any latch turns the address lines into row-drive lines. One address drives the same row index in both halves, and an active-low output enable blanks every row. The oldest bit of each chain leaves on a serial output, so a second panel can be chained behind this one.

A LED at upper-half row r, column c of plane p lights when sink bit p*COLS+c is 1 and row line r is driven. For the lower half, the row line is r+SCAN.

Top module: `led_panel_model`

## Requirements
- R1: While `rst` is high, every chain stage and every latch is cleared. With `oe_n` high this makes `sink`, `ser_out` and `row_on` all zero.
- R2: On each rising `clk` edge, `ser_in[p]` enters stage COLS-1 of chain p, and every other stage takes the value of the stage above it. Plane order is: bit 0 upper red, 1 upper green, 2 upper blue, 3 lower red, 4 lower green, 5 lower blue.
- R3: After COLS edges, the first bit shifted in sits at column 0 and the last at column COLS-1. Column c of plane p appears on `sink[p*COLS+c]`.
- R4: `ser_out[p]` is stage 0 of chain p, the oldest bit, which is the bit the next edge pushes out of the panel.
- R5: While `lat` is high, `sink` follows the chain contents with no clock edge needed. A sink bit of 1 means that column sink is active.
- R6: While `lat` is low, `sink` keeps its value no matter how many bits are shifted.
- R7: While `oe_n` is high, every bit of `row_on` is 0.
- R8: While `oe_n` is low, exactly two bits of `row_on` are set: bit `addr` (upper half) and bit `addr`+SCAN (lower half), where SCAN = 2**ADDR_W.
- R9: `row_on` follows `addr` and `oe_n` within the same time step, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Panel shift clock; shifting happens on its rising edge |
| rst | input | 1 | Active-high reset, clears chains and latches |
| ser_in | input | 6 | Serial colour inputs, one per plane (order in R2) |
| lat | input | 1 | Latch strobe, transparent while high |
| oe_n | input | 1 | Active-low output enable for the row drivers |
| addr | input | ADDR_W | Row address, not latched |
| ser_out | output | 6 | Oldest bit of each chain, for the next panel |
| sink | output | 6*COLS | Latched column sink states, plane-major |
| row_on | output | 2*SCAN | Row-drive lines; upper half in the low SCAN bits |

## Verification
The row outputs depend only on `addr` and `oe_n`, so the bench checks them a fraction of a nanosecond after every input change, including several changes within one clock period. A new serial bit reaches column COLS-1 one edge after it is presented, and reaches `ser_out` COLS edges later. The latch output takes a new value as soon as `lat` rises, or right after an edge while `lat` stays high. For that reason, chain, latch and serial-output results are compared at the falling edge that follows each rising edge. The strobe-rise ordering check is taken right after `lat` rises, before the next edge.

// File: rtl/led_panel_pkg.sv
`timescale 1ns/1ps
package led_panel_pkg;
  localparam int PLANES = 6;

  typedef enum logic [2:0] {
    PL_UP_RED   = 3'd0,
    PL_UP_GREEN = 3'd1,
    PL_UP_BLUE  = 3'd2,
    PL_LO_RED   = 3'd3,
    PL_LO_GREEN = 3'd4,
    PL_LO_BLUE  = 3'd5
  } plane_e;
endpackage

// File: rtl/led_shift_chain.sv
`timescale 1ns/1ps
module led_shift_chain #(
  parameter int COLS = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            din,
  output logic [COLS-1:0] stages,
  output logic            dout
);
  logic [COLS-1:0] q;

  // New bit enters at the top index; the oldest bit sits at index 0.
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= {din, q[COLS-1:1]};
  end

  assign stages = q;
  assign dout   = q[0];
endmodule

// File: rtl/led_latch_bank.sv
`timescale 1ns/1ps
module led_latch_bank #(
  parameter int WIDTH = 192
) (
  input  logic             rst,
  input  logic             lat,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] held;

  // Level-sensitive storage: open while lat is high.
  always_latch begin
    if (rst)      held = '0;
    else if (lat) held = d;
  end

  assign q = held;
endmodule

// File: rtl/led_row_decoder.sv
`timescale 1ns/1ps
module led_row_decoder #(
  parameter int ADDR_W = 4
) (
  input  logic                      oe_n,
  input  logic [ADDR_W-1:0]         addr,
  output logic [(2**(ADDR_W+1))-1:0] row_on
);
  always_comb begin
    row_on = '0;
    if (!oe_n) begin
      row_on[{1'b0, addr}] = 1'b1;
      row_on[{1'b1, addr}] = 1'b1;
    end
  end
endmodule

// File: rtl/led_panel_model.sv
`timescale 1ns/1ps
module led_panel_model
  import led_panel_pkg::*;
#(
  parameter int COLS   = 32,
  parameter int ADDR_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [PLANES-1:0]      ser_in,
  input  logic                   lat,
  input  logic                   oe_n,
  input  logic [ADDR_W-1:0]      addr,
  output logic [PLANES-1:0]      ser_out,
  output logic [PLANES*COLS-1:0] sink,
  output logic [2*(2**ADDR_W)-1:0] row_on
);
  localparam int SCAN  = 2 ** ADDR_W;
  localparam int BANKW = PLANES * COLS;

  logic [BANKW-1:0] chain_all;

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    led_shift_chain #(.COLS(COLS)) u_chain (
      .clk    (clk),
      .rst    (rst),
      .din    (ser_in[p]),
      .stages (chain_all[p*COLS +: COLS]),
      .dout   (ser_out[p])
    );
  end

  led_latch_bank #(.WIDTH(BANKW)) u_latch (
    .rst (rst),
    .lat (lat),
    .d   (chain_all),
    .q   (sink)
  );

  led_row_decoder #(.ADDR_W(ADDR_W)) u_rows (
    .oe_n   (oe_n),
    .addr   (addr),
    .row_on (row_on)
  );

  if (2 * SCAN != $bits(row_on)) begin : g_bad_width
    initial $error("row_on width mismatch");
  end
endmodule

// File: rtl/led_panel_chk.sv
`timescale 1ns/1ps
module led_panel_chk #(
  parameter int COLS   = 32,
  parameter int ADDR_W = 4,
  parameter int PLANES = 6
) (
  input logic                     clk,
  input logic                     rst,
  input logic [PLANES-1:0]        ser_in,
  input logic                     lat,
  input logic                     oe_n,
  input logic [ADDR_W-1:0]        addr,
  input logic [PLANES-1:0]        ser_out,
  input logic [PLANES*COLS-1:0]   sink,
  input logic [2*(2**ADDR_W)-1:0] row_on
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  p_blank_r7: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (row_on == '0));

  p_pair_r8: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> ($countones(row_on) == 2 && row_on[{1'b0, addr}] && row_on[{1'b1, addr}]));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (armed && !lat && !$past(lat)) |-> $stable(sink));

  for (genvar p = 0; p < PLANES; p++) begin : g_pl
    p_entry_r2: assert property (@(posedge clk) disable iff (rst)
      (armed && lat) |-> (sink[p*COLS+COLS-1] == $past(ser_in[p])));

    p_tail_r4: assert property (@(posedge clk) disable iff (rst)
      (armed && lat && $past(lat)) |-> (ser_out[p] == $past(sink[p*COLS+1])));
  end
endmodule

bind led_panel_model led_panel_chk #(.COLS(COLS), .ADDR_W(ADDR_W), .PLANES(6)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ser_in  (ser_in),
  .lat     (lat),
  .oe_n    (oe_n),
  .addr    (addr),
  .ser_out (ser_out),
  .sink    (sink),
  .row_on  (row_on)
);

// File: tb/sim_led_panel_model.sv
`timescale 1ns/1ps
module sim_led_panel_model;
  localparam int COLS   = 32;
  localparam int ADDR_W = 4;
  localparam int SCAN   = 2 ** ADDR_W;
  localparam int NP     = 6;
  localparam int W      = NP * COLS;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NP-1:0]     ser_in = '0;
  logic              lat = 1'b0;
  logic              oe_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [NP-1:0]     ser_out;
  logic [W-1:0]      sink;
  logic [2*SCAN-1:0] row_on;

  int checks = 0;
  int errors = 0;

  bit m_q[NP][$];
  bit m_held[NP][COLS];
  logic [15:0] lf = 16'hACE1;

  always #2.5 clk = ~clk;

  led_panel_model #(.COLS(COLS), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .ser_in(ser_in), .lat(lat), .oe_n(oe_n),
    .addr(addr), .ser_out(ser_out), .sink(sink), .row_on(row_on)
  );

  task automatic cmp(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] next_bits();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[6:0];
  endfunction

  function automatic logic [W-1:0] exp_sink();
    logic [W-1:0] v = '0;
    for (int p = 0; p < NP; p++)
      for (int c = 0; c < COLS; c++) v[p*COLS+c] = m_held[p][c];
    return v;
  endfunction

  function automatic logic [W-1:0] exp_rows();
    logic [W-1:0] v = '0;
    for (int r = 0; r < 2*SCAN; r++) v[r] = !oe_n && ((r % SCAN) == int'(addr));
    return v;
  endfunction

  function automatic logic [W-1:0] exp_tail();
    logic [W-1:0] v = '0;
    for (int p = 0; p < NP; p++) v[p] = m_q[p][0];
    return v;
  endfunction

  task automatic open_latch_model();
    for (int p = 0; p < NP; p++)
      for (int c = 0; c < COLS; c++) m_held[p][c] = m_q[p][c];
  endtask

  task automatic check_rows(input string tag);
    cmp(tag, W'(row_on), exp_rows());
  endtask

  // Drive inputs, let one rising edge pass, compare at the following falling edge.
  task automatic tick(input logic [NP-1:0] s, input logic l, input logic o, input logic [ADDR_W-1:0] a);
    ser_in = s; lat = l; oe_n = o; addr = a;
    #0.2;
    if (l) open_latch_model();
    check_rows(o ? "R7 rows blank" : "R8 row pair");
    @(posedge clk);
    for (int p = 0; p < NP; p++) begin
      m_q[p].push_back(s[p]);
      void'(m_q[p].pop_front());
    end
    if (l) open_latch_model();
    @(negedge clk);
    cmp(l ? "R5 transparent sink" : "R6 held sink", sink, exp_sink());
    cmp("R4 serial out", W'(ser_out), exp_tail());
    if (l) cmp("R2 entry stage", W'({sink[5*COLS+COLS-1], sink[4*COLS+COLS-1], sink[3*COLS+COLS-1],
                                     sink[2*COLS+COLS-1], sink[COLS+COLS-1], sink[COLS-1]}), W'(s));
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog R1..: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [NP-1:0] first_b, last_b, s;
    logic [6:0] rb;
    for (int p = 0; p < NP; p++)
      for (int c = 0; c < COLS; c++) begin
        m_q[p].push_back(1'b0);
        m_held[p][c] = 1'b0;
      end

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state observed at the ports
    cmp("R1 reset sink", sink, '0);
    cmp("R1 reset ser_out", W'(ser_out), '0);
    cmp("R1 reset rows", W'(row_on), '0);
    rst = 1'b0;

    // Fill chains with latch closed (R6), recording first and last bits
    first_b = '0; last_b = '0;
    for (int k = 0; k < COLS; k++) begin
      rb = next_bits();
      s = rb[5:0];
      if (k == 0) first_b = s;
      last_b = s;
      tick(s, 1'b0, 1'b0, ADDR_W'(k));
    end

    // R3: open latch between edges and check column ordering
    lat = 1'b1;
    #0.2;
    for (int p = 0; p < NP; p++) begin
      cmp("R3 first bit at column 0", W'(sink[p*COLS]), W'(first_b[p]));
      cmp("R3 last bit at column COLS-1", W'(sink[p*COLS+COLS-1]), W'(last_b[p]));
    end
    open_latch_model();
    cmp("R5 opens without edge", sink, exp_sink());

    // Transparent shifting
    for (int k = 0; k < 12; k++) begin
      rb = next_bits();
      tick(rb[5:0], 1'b1, rb[6], ADDR_W'(k + 3));
    end

    // Closed latch, long shifting: held values survive (R6)
    for (int k = 0; k < 2*COLS; k++) begin
      rb = next_bits();
      tick(rb[5:0], 1'b0, rb[6], ADDR_W'(k * 5));
    end

    // Mixed strobe patterns
    for (int k = 0; k < 3*COLS; k++) begin
      rb = next_bits();
      tick(rb[5:0], rb[6] & rb[2], rb[1], ADDR_W'(rb[6:3]));
    end

    // R9: rows follow address and enable within one clock period
    for (int a = 0; a < SCAN; a++) begin
      oe_n = 1'b0; addr = ADDR_W'(a);
      #0.4 check_rows("R9 row follows addr");
      oe_n = 1'b1;
      #0.4 check_rows("R9 blank follows oe_n");
      addr = ADDR_W'(SCAN - 1 - a);
      #0.4 check_rows("R9 addr change while blank");
      oe_n = 1'b0;
      #0.4 check_rows("R9 enable without edge");
      tick(6'b0, 1'b0, 1'b0, ADDR_W'(a));
    end

    // Drain chains: all-ones then zeros, latch open
    for (int k = 0; k < COLS + 2; k++) tick(6'h3F, 1'b1, 1'b1, '0);
    for (int k = 0; k < COLS + 2; k++) tick(6'h00, 1'b1, 1'b0, '1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule